// File: doc/BRIEF.md
# Boot Region Address Remap Decoder

This block decodes the address of every request from a processor master and names one of three memory targets: the boot ROM, the on-chip RAM or the external SDRAM. It also returns the offset inside the chosen target and raises a decode-error flag when no target may answer. The decode is purely combinational. The only state is two software-written controls, and both reach it through a small register write port.

The lowest 1 MB of the address space is the boot window, and its routing is a two-level choice. The filter-start control comes first. Addresses in the window below its value belong to the boot logic, and the rest go to SDRAM, so a value of 0x100000 claims the whole window and 0 hands it all to SDRAM. Inside a claimed window the remap bit then puts either the boot ROM or the on-chip RAM at address zero. Each memory is 64 KB, so the rest of a claimed window is illegal.

Both memories also keep fixed high aliases that neither control moves. A request flagged as coming from another master ignores both controls and sees a fixed low map with the on-chip RAM at zero.

Top module: `boot_remap_dec`

## Requirements
- R1: While `req_valid_i` is high, exactly one of `sel_rom_o`, `sel_ram_o`, `sel_sdram_o`, `dec_err_o` is high. While it is low, all four are low and `offset_o` is 0.
- R2: After reset the filter-start control holds 0x100000 and the remap bit holds 0, so a processor request to address 0 selects the boot ROM with offset 0.
- R3: For a processor request with address below both 0x10000 and the filter-start value, the target is the boot ROM when the remap bit is 0 and the on-chip RAM when it is 1. The offset is the low 16 bits of the address.
- R4: For a processor request in 0x10000..0xFFFFF that lies below the filter-start value, `dec_err_o` is raised and the offset is 0.
- R5: For a processor request below 0x100000 whose address is at or above the filter-start value, the target is SDRAM and the offset equals the address. With the filter-start control at 0, the whole window goes to SDRAM.
- R6: Addresses 0xFFFD0000..0xFFFDFFFF select the boot ROM with offset address−0xFFFD0000, whatever either control holds.
- R7: Addresses 0xFFFF0000..0xFFFFFFFF select the on-chip RAM with offset address−0xFFFF0000, whatever either control holds.
- R8: A request with `req_cpu_i` low ignores both controls. Addresses below 0x10000 select the on-chip RAM with the low 16 bits as offset, and the rest of the window gives a decode error.
- R9: A write with `cfg_sel_i`=0 loads the filter-start control from all 32 data bits. A write with `cfg_sel_i`=1 loads the remap bit from data bit 0. Either change affects the decode from the first cycle after the write edge and not before.
- R10: Addresses 0x100000..0xBFFFFFFF select SDRAM with offset equal to the address. Addresses 0xC0000000..0xFFFCFFFF and 0xFFFE0000..0xFFFEFFFF give a decode error with offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_sel_i | input | 1 | Control select: 0 filter-start, 1 remap bit |
| cfg_wdata_i | input | 32 | Control write data |
| req_valid_i | input | 1 | Request present |
| req_cpu_i | input | 1 | Request comes from the processor master |
| req_addr_i | input | 32 | Request address |
| sel_rom_o | output | 1 | Boot ROM selected |
| sel_ram_o | output | 1 | On-chip RAM selected |
| sel_sdram_o | output | 1 | SDRAM selected |
| dec_err_o | output | 1 | Decode error |
| offset_o | output | 32 | Offset inside the selected target |

## Verification
The assertions assume that the parameters give non-overlapping regions, with the SDRAM top at or below the ROM alias base. They assume that the control inputs are stable around the clock edge. The window-error property assumes the filter-start value is either 0 or exactly the window size. The bench meets all of this by writing only those two filter values and by changing every input at the falling edge, half a period away from the sampling edge.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    TGT_ROM   = 2'd0,
    TGT_RAM   = 2'd1,
    TGT_SDRAM = 2'd2,
    TGT_ERR   = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [ADDR_W-1:0] off;
  } route_t;
endpackage

// File: rtl/boot_remap_cfg.sv
module boot_remap_cfg
  import boot_remap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FILT_RST = 32'h0010_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] filter_o,
  output logic              remap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filter_o <= FILT_RST;
      remap_o  <= 1'b0;
    end else if (we_i) begin
      if (sel_i) remap_o  <= wdata_i[0];
      else       filter_o <= wdata_i;
    end
  end
endmodule

// File: rtl/boot_remap_win.sv
module boot_remap_win
  import boot_remap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] MEM_SIZE = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_i,
  input  logic [ADDR_W-1:0] filter_i,
  input  logic              remap_i,
  output logic              hit_o,
  output route_t            route_o
);
  localparam logic [ADDR_W-1:0] MEM_MASK = MEM_SIZE - 32'd1;

  assign hit_o = addr_i < WIN_SIZE;

  // level 1: filter hands the window to SDRAM; level 2: remap picks ROM/RAM
  always_comb begin
    route_o = '{tgt: TGT_ERR, off: '0};
    if (cpu_i && (addr_i >= filter_i)) begin
      route_o = '{tgt: TGT_SDRAM, off: addr_i};
    end else if (addr_i < MEM_SIZE) begin
      route_o.tgt = (!cpu_i || remap_i) ? TGT_RAM : TGT_ROM;
      route_o.off = addr_i & MEM_MASK;
    end
  end
endmodule

// File: rtl/boot_remap_alias.sv
module boot_remap_alias
  import boot_remap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFD_0000,
  parameter logic [ADDR_W-1:0] SIZE = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);
  logic [ADDR_W-1:0] diff;

  assign diff  = addr_i - BASE;
  assign hit_o = (addr_i >= BASE) && (diff < SIZE);
  assign off_o = hit_o ? diff : '0;
endmodule

// File: rtl/boot_remap_dec.sv
module boot_remap_dec
  import boot_remap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] MEM_SIZE  = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'hFFFD_0000,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] SDRAM_TOP = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] FILT_RST  = 32'h0010_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic              req_cpu_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              sel_rom_o,
  output logic              sel_ram_o,
  output logic              sel_sdram_o,
  output logic              dec_err_o,
  output logic [ADDR_W-1:0] offset_o
);
  localparam int unsigned NALIAS = 2;
  localparam logic [ADDR_W-1:0] ALIAS_BASE [NALIAS] = '{ROM_BASE, RAM_BASE};
  localparam tgt_e               ALIAS_TGT  [NALIAS] = '{TGT_ROM, TGT_RAM};

  logic [ADDR_W-1:0] filter_q;
  logic              remap_q;
  logic              win_hit;
  route_t            win_route;
  logic [NALIAS-1:0]             alias_hit;
  logic [NALIAS-1:0][ADDR_W-1:0] alias_off;
  route_t            route;

  boot_remap_cfg #(.FILT_RST(FILT_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .filter_o(filter_q),
    .remap_o (remap_q)
  );

  boot_remap_win #(.WIN_SIZE(WIN_SIZE), .MEM_SIZE(MEM_SIZE)) u_win (
    .addr_i  (req_addr_i),
    .cpu_i   (req_cpu_i),
    .filter_i(filter_q),
    .remap_i (remap_q),
    .hit_o   (win_hit),
    .route_o (win_route)
  );

  for (genvar g = 0; g < NALIAS; g++) begin : g_alias
    boot_remap_alias #(.BASE(ALIAS_BASE[g]), .SIZE(MEM_SIZE)) u_alias (
      .addr_i(req_addr_i),
      .hit_o (alias_hit[g]),
      .off_o (alias_off[g])
    );
  end

  always_comb begin
    route = '{tgt: TGT_ERR, off: '0};
    if (win_hit) begin
      route = win_route;
    end else if (req_addr_i < SDRAM_TOP) begin
      route = '{tgt: TGT_SDRAM, off: req_addr_i};
    end else begin
      for (int i = 0; i < NALIAS; i++) begin
        if (alias_hit[i]) route = '{tgt: ALIAS_TGT[i], off: alias_off[i]};
      end
    end
  end

  assign sel_rom_o   = req_valid_i && (route.tgt == TGT_ROM);
  assign sel_ram_o   = req_valid_i && (route.tgt == TGT_RAM);
  assign sel_sdram_o = req_valid_i && (route.tgt == TGT_SDRAM);
  assign dec_err_o   = req_valid_i && (route.tgt == TGT_ERR);
  assign offset_o    = (req_valid_i && route.tgt != TGT_ERR) ? route.off : '0;
endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk
  import boot_remap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] MEM_SIZE = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 32'hFFFD_0000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'hFFFF_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              cfg_sel_i,
  input logic [ADDR_W-1:0] cfg_wdata_i,
  input logic              req_valid_i,
  input logic              req_cpu_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              sel_rom_o,
  input logic              sel_ram_o,
  input logic              sel_sdram_o,
  input logic              dec_err_o,
  input logic [ADDR_W-1:0] offset_o,
  input logic [ADDR_W-1:0] filter_q,
  input logic              remap_q
);
  logic in_rom_alias, in_ram_alias, in_win_gap;
  assign in_rom_alias = (req_addr_i >= ROM_BASE) && (req_addr_i - ROM_BASE < MEM_SIZE);
  assign in_ram_alias = (req_addr_i >= RAM_BASE) && (req_addr_i - RAM_BASE < MEM_SIZE);
  assign in_win_gap   = (req_addr_i >= MEM_SIZE) && (req_addr_i < WIN_SIZE);

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot({sel_rom_o, sel_ram_o, sel_sdram_o, dec_err_o}));

  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> ({sel_rom_o, sel_ram_o, sel_sdram_o, dec_err_o} == 4'b0 && offset_o == '0));

  a_r3_mem_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rom_o || sel_ram_o) |-> (offset_o < MEM_SIZE));

  a_r4_window_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_cpu_i && in_win_gap && filter_q == WIN_SIZE) |-> (dec_err_o && offset_o == '0));

  a_r6_rom_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && in_rom_alias) |-> (sel_rom_o && offset_o == req_addr_i - ROM_BASE));

  a_r7_ram_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && in_ram_alias) |-> (sel_ram_o && offset_o == req_addr_i - RAM_BASE));

  a_r8_other_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_cpu_i && req_addr_i < MEM_SIZE) |-> sel_ram_o);

  a_r9_remap_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i) |=> (remap_q == $past(cfg_wdata_i[0])));

  a_r9_filter_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_sel_i) |=> (filter_q == $past(cfg_wdata_i)));
endmodule

bind boot_remap_dec boot_remap_chk #(
  .WIN_SIZE(WIN_SIZE), .MEM_SIZE(MEM_SIZE), .ROM_BASE(ROM_BASE), .RAM_BASE(RAM_BASE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .cfg_wdata_i(cfg_wdata_i),
  .req_valid_i(req_valid_i),
  .req_cpu_i  (req_cpu_i),
  .req_addr_i (req_addr_i),
  .sel_rom_o  (sel_rom_o),
  .sel_ram_o  (sel_ram_o),
  .sel_sdram_o(sel_sdram_o),
  .dec_err_o  (dec_err_o),
  .offset_o   (offset_o),
  .filter_q   (filter_q),
  .remap_q    (remap_q)
);

// File: tb/boot_remap_dec_tb_top.sv
module boot_remap_dec_tb_top;
  // expected codes {err, sdram, ram, rom}
  localparam logic [3:0] E_ROM = 4'b0001, E_RAM = 4'b0010, E_SDR = 4'b0100, E_ERR = 4'b1000;
  localparam int NV = 14;
  // {cpu, addr, expected code, expected offset}, default controls
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 32'h0000_0000, E_ROM, 32'h0000_0000},
    {1'b1, 32'h0000_FFFF, E_ROM, 32'h0000_FFFF},
    {1'b1, 32'h0001_0000, E_ERR, 32'h0000_0000},
    {1'b1, 32'h000F_FFFF, E_ERR, 32'h0000_0000},
    {1'b1, 32'h0010_0000, E_SDR, 32'h0010_0000},
    {1'b1, 32'hBFFF_FFFF, E_SDR, 32'hBFFF_FFFF},
    {1'b1, 32'hC000_0000, E_ERR, 32'h0000_0000},
    {1'b1, 32'hFFFC_FFFF, E_ERR, 32'h0000_0000},
    {1'b1, 32'hFFFD_1234, E_ROM, 32'h0000_1234},
    {1'b1, 32'hFFFE_0000, E_ERR, 32'h0000_0000},
    {1'b1, 32'hFFFF_ABCD, E_RAM, 32'h0000_ABCD},
    {1'b1, 32'hFFFF_FFFF, E_RAM, 32'h0000_FFFF},
    {1'b0, 32'h0000_0040, E_RAM, 32'h0000_0040},
    {1'b0, 32'h0002_0000, E_ERR, 32'h0000_0000}
  };
  localparam string VTAG [NV] = '{"R2", "R3", "R4", "R4", "R10", "R10", "R10",
                                  "R10", "R6", "R10", "R7", "R7", "R8", "R8"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0, req_cpu_i = 1'b1;
  logic [31:0] req_addr_i = '0;
  logic        sel_rom_o, sel_ram_o, sel_sdram_o, dec_err_o;
  logic [31:0] offset_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  boot_remap_dec dut_i (.*);

  task automatic chk(string tag, logic [3:0] exp_c, logic [31:0] exp_o);
    logic [3:0] got;
    got = {dec_err_o, sel_sdram_o, sel_ram_o, sel_rom_o};
    n_chk++;
    if (got !== exp_c || offset_o !== exp_o) begin
      n_fail++;
      $display("FAIL %s addr=%h cpu=%0b: sel=%b off=%h, expected sel=%b off=%h",
               tag, req_addr_i, req_cpu_i, got, offset_o, exp_c, exp_o);
    end
  endtask

  task automatic req(logic cpu, logic [31:0] a);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_cpu_i = cpu; req_addr_i = a;
    #1;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #5;
    chk("R1 idle in reset", 4'b0000, 32'h0);
    req_valid_i = 1'b1; req_cpu_i = 1'b1; req_addr_i = 32'h0; #1;
    chk("R2 reset map", E_ROM, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      req(VEC[i][68], VEC[i][67:36]);
      chk(VTAG[i], VEC[i][35:32], VEC[i][31:0]);
    end

    @(negedge clk_i); req_valid_i = 1'b0; #1;
    chk("R1 idle", 4'b0000, 32'h0);

    // R9: remap write visible only after the edge
    @(negedge clk_i);
    req_valid_i = 1'b1; req_cpu_i = 1'b1; req_addr_i = 32'h10;
    cfg_we_i = 1'b1; cfg_sel_i = 1'b1; cfg_wdata_i = 32'h1; #1;
    chk("R9 before edge", E_ROM, 32'h10);
    @(posedge clk_i); #1;
    chk("R9 after edge", E_RAM, 32'h10);
    @(negedge clk_i); cfg_we_i = 1'b0;

    req(1'b1, 32'h0000_FFF0); chk("R3 remap ram", E_RAM, 32'hFFF0);
    req(1'b1, 32'h0001_0000); chk("R4 remap gap", E_ERR, 32'h0);
    req(1'b1, 32'hFFFD_0008); chk("R6 alias w/ remap", E_ROM, 32'h8);
    req(1'b0, 32'h0000_0010); chk("R8 other w/ remap", E_RAM, 32'h10);

    wr(1'b0, 32'h0);
    req(1'b1, 32'h0000_0010); chk("R5 filter 0 low", E_SDR, 32'h10);
    req(1'b1, 32'h0002_0000); chk("R5 filter 0 gap", E_SDR, 32'h0002_0000);
    req(1'b0, 32'h0000_0010); chk("R8 other w/ filter 0", E_RAM, 32'h10);
    req(1'b1, 32'hFFFF_0004); chk("R7 alias w/ filter 0", E_RAM, 32'h4);

    wr(1'b0, 32'h0010_0000);
    wr(1'b1, 32'h0);
    req(1'b1, 32'h0000_0020); chk("R3 remap back rom", E_ROM, 32'h20);

    wr(1'b1, 32'h1);
    @(negedge clk_i); rst_ni = 1'b0; req_addr_i = 32'h0; #1;
    chk("R2 async reset", E_ROM, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule